// File: doc/BRIEF.md
# Serial Sampling-Converter Host Sequencer

This block sits in the host's clock domain and runs a 16-bit successive-approximation converter that has a serial output. When a start is requested, it pulls the convert strobe and the chip select low together. It holds the strobe low for a programmed number of cycles and then releases it while the converter is still busy. It then watches the converter's busy line, using a two-stage synchronizer, until the line has gone low and come back high. After that it collects the 16-bit result in one of two ways.

The read mode is latched at each start. In converter-clocked mode, the converter clocks out the word of the previous conversion during the present one. The sequencer samples that word on the rising edges of the converter's clock. In host-clocked mode, the sequencer itself produces a read clock once the conversion is finished. It waits for the frame marker and then takes the 16 bits of the conversion that has just completed. The finished word is given one of two codings and is held until the next one replaces it.

A start request that arrives while the sequencer is occupied is remembered and served later. A power-down request blocks all new conversions. A busy line that never completes ends the transaction with an error pulse. A busy line that rises while the strobe is still low is reported as a violation.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the strobe and the chip select are high (inactive). The read clock, the valid pulse, both error pulses and the power-down pin are low, and the result is 0x0000.
- R2: A start drives the strobe and the chip select low in the same cycle. The strobe stays low for exactly STROBE_CYC cycles and then returns high. The chip select stays low until the transaction ends, and the strobe is never low while the chip select is high.
- R3: Two successive strobe falling edges are never closer than SPACING_CYC cycles.
- R4: In converter-clocked mode, bits are taken MSB first on rising edges of the converter clock. Once 16 bits are in, a one-cycle valid pulse is raised. The word delivered belongs to the conversion before the one just started.
- R5: In host-clocked mode, the sequencer starts its read clock after busy returns high. Each half period of the clock lasts RCLK_HALF cycles. On a rising edge where the frame marker is seen high, the next 16 rising edges each take one bit, MSB first. The word delivered belongs to the conversion just finished.
- R6: With the coding select at 0, the two's-complement word passes through unchanged. With it at 1, bit 15 is inverted to give straight binary: 0x0000→0x8000, 0x7FFF→0xFFFF, 0x8000→0x0000, 0xFFFF→0x7FFF.
- R7: A start request that arrives during a transaction is held, and it causes exactly one further conversion later.
- R8: The power-down pin follows the power-down request one cycle later. While it is high, no strobe is issued and the result does not change. A start requested during power-down is carried out once power-down is released.
- R9: If busy has not gone low and then high again within BUSY_TMO_CYC cycles after the strobe ends, a one-cycle timeout pulse is raised. The strobe and the chip select return high in that same cycle.
- R10: If busy is seen rising while the strobe and the chip select are both low, a one-cycle violation pulse is raised. The pulse is never raised in normal operation.
- R11: The result changes only in a cycle where the valid pulse is high.
- R12: The host read clock is low whenever the chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to start a conversion |
| use_ext_clk | input | 1 | 1: host-clocked read, 0: converter-clocked read (latched at start) |
| fmt_straight | input | 1 | 1: straight binary output, 0: two's complement |
| pwr_down_req | input | 1 | Power-down request |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_dclk_in | input | 1 | Converter-driven data clock |
| adc_data | input | 1 | Serial data from the converter |
| adc_sync | input | 1 | Frame marker in host-clocked mode |
| adc_rc_n | output | 1 | Convert strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_dclk_out | output | 1 | Host-driven read clock |
| adc_pwrd | output | 1 | Power-down to the converter |
| result | output | 16 | Last converted word in the chosen coding |
| result_valid | output | 1 | One-cycle pulse when a new result is present |
| busy_timeout_err | output | 1 | One-cycle busy timeout pulse |
| strobe_violation | output | 1 | One-cycle pulse when busy rises under a low strobe |

## Verification
The bench builds the sequencer with an 8-cycle strobe, a 200-cycle spacing, a 300-cycle busy timeout and a 2-cycle read-clock half period. At these values each conversion takes a few hundred cycles. That makes it possible to sweep the four coding corners and twelve computed words through both read modes and both codings, and so to follow the one-conversion lag across every change of mode. The converter model in the bench can be set to a 2-cycle conversion, which makes busy rise inside the strobe. It can also be set to never answer, which forces a timeout. Pending-start and power-down cases fit in one short run.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_READ   = 2'd3
    } adc_seq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [1:0] stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= {stage_q[0], d_i[g]};
        end
        assign q_o[g] = stage_q[1];
    end
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         full_o
);
    localparam int NW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  word;
        logic [NW-1:0] cnt;
        logic          full;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d      = q;
        d.full = 1'b0;
        if (clr_i) begin
            d.cnt = '0;
        end else if (en_i && (q.cnt < NW'(W))) begin
            d.word = {q.word[W-2:0], bit_i};
            d.cnt  = q.cnt + 1'b1;
            d.full = (q.cnt == NW'(W - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o = q.word;
    assign full_o = q.full;
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    input  logic         straight_i,
    output logic [W-1:0] coded_o
);
    always_comb begin
        coded_o        = raw_i;
        coded_o[W-1]   = raw_i[W-1] ^ straight_i;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int STROBE_CYC   = 8,
    parameter int SPACING_CYC  = 1250,
    parameter int BUSY_TMO_CYC = 1100,
    parameter int RCLK_HALF    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              use_ext_clk,
    input  logic              fmt_straight,
    input  logic              pwr_down_req,
    input  logic              adc_busy,
    input  logic              adc_dclk_in,
    input  logic              adc_data,
    input  logic              adc_sync,
    output logic              adc_rc_n,
    output logic              adc_cs_n,
    output logic              adc_dclk_out,
    output logic              adc_pwrd,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              busy_timeout_err,
    output logic              strobe_violation
);
    localparam int MAX_A = (STROBE_CYC > BUSY_TMO_CYC) ? STROBE_CYC : BUSY_TMO_CYC;
    localparam int MAX_C = (MAX_A > RCLK_HALF) ? MAX_A : RCLK_HALF;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam int GW    = $clog2(SPACING_CYC + 1);
    localparam int EW    = $clog2(DATA_W + 4);

    typedef struct packed {
        adc_seq_state_e    st;
        logic [CW-1:0]     cnt;
        logic [GW-1:0]     gap;
        logic [EW-1:0]     edges;
        logic [DATA_W-1:0] res;
        logic              pend;
        logic              rc_n;
        logic              cs_n;
        logic              dclk;
        logic              armed;
        logic              ext;
        logic              seen_low;
        logic              busy_prev;
        logic              dclk_prev;
        logic              valid;
        logic              tmo;
        logic              viol;
        logic              pwrd;
    } seq_t;

    seq_t q, d;

    logic [3:0]        sync_in, sync_out;
    logic              busy_s, dclk_s, data_s, mark_s;
    logic              shift_en, shift_clr, shift_full;
    logic [DATA_W-1:0] shift_word, coded_word;

    assign sync_in = {adc_sync, adc_data, adc_dclk_in, adc_busy};

    adc_seq_sync #(.N(4)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (sync_in),
        .q_o  (sync_out)
    );

    assign busy_s = sync_out[0];
    assign dclk_s = sync_out[1];
    assign data_s = sync_out[2];
    assign mark_s = sync_out[3];

    adc_seq_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (shift_clr),
        .en_i  (shift_en),
        .bit_i (data_s),
        .word_o(shift_word),
        .full_o(shift_full)
    );

    adc_seq_fmt #(.W(DATA_W)) u_fmt (
        .raw_i     (shift_word),
        .straight_i(fmt_straight),
        .coded_o   (coded_word)
    );

    always_comb begin
        d           = q;
        d.valid     = 1'b0;
        d.tmo       = 1'b0;
        d.viol      = 1'b0;
        d.pwrd      = pwr_down_req;
        d.busy_prev = busy_s;
        d.dclk_prev = dclk_s;
        shift_en    = 1'b0;
        shift_clr   = 1'b0;

        if (start_req)       d.pend = 1'b1;
        if (q.gap != '0)     d.gap  = q.gap - 1'b1;
        if (!busy_s)         d.seen_low = 1'b1;
        if (busy_s && !q.busy_prev && !q.rc_n && !q.cs_n) d.viol = 1'b1;
        if (shift_full) begin
            d.res   = coded_word;
            d.valid = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if ((q.pend || start_req) && !q.pwrd && (q.gap == '0)) begin
                    d.pend     = 1'b0;
                    d.st       = ST_STROBE;
                    d.rc_n     = 1'b0;
                    d.cs_n     = 1'b0;
                    d.cnt      = CW'(STROBE_CYC - 1);
                    d.gap      = GW'(SPACING_CYC - 1);
                    d.seen_low = 1'b0;
                    d.ext      = use_ext_clk;
                    shift_clr  = 1'b1;
                end
            end
            ST_STROBE: begin
                if (!q.ext && dclk_s && !q.dclk_prev) shift_en = 1'b1;
                if (q.cnt == '0) begin
                    d.rc_n = 1'b1;
                    d.st   = ST_WAIT;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (!q.ext && dclk_s && !q.dclk_prev) shift_en = 1'b1;
                if (busy_s && q.seen_low) begin
                    if (q.ext) begin
                        d.st    = ST_READ;
                        d.cnt   = '0;
                        d.edges = '0;
                        d.armed = 1'b0;
                        d.dclk  = 1'b0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.cs_n = 1'b1;
                    end
                end else if (q.cnt == CW'(BUSY_TMO_CYC - 1)) begin
                    d.tmo  = 1'b1;
                    d.st   = ST_IDLE;
                    d.cs_n = 1'b1;
                    d.rc_n = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (shift_full) begin
                    d.st   = ST_IDLE;
                    d.cs_n = 1'b1;
                    d.dclk = 1'b0;
                end else if (q.cnt == CW'(RCLK_HALF - 1)) begin
                    d.cnt  = '0;
                    d.dclk = !q.dclk;
                    if (!q.dclk) begin
                        d.edges = q.edges + 1'b1;
                        if (q.edges == EW'(DATA_W + 2)) begin
                            d.st   = ST_IDLE;
                            d.cs_n = 1'b1;
                            d.dclk = 1'b0;
                        end else if (q.armed) begin
                            shift_en = 1'b1;
                        end else if (mark_s) begin
                            d.armed = 1'b1;
                        end
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.rc_n <= 1'b1;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_rc_n         = q.rc_n;
    assign adc_cs_n         = q.cs_n;
    assign adc_dclk_out     = q.dclk;
    assign adc_pwrd         = q.pwrd;
    assign result           = q.res;
    assign result_valid     = q.valid;
    assign busy_timeout_err = q.tmo;
    assign strobe_violation = q.viol;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_rc_n,
    input logic              adc_cs_n,
    input logic              adc_dclk_out,
    input logic              adc_pwrd,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic              busy_timeout_err
);
    assert_rc_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rc_n |-> !adc_cs_n);

    assert_strobe_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_rc_n) && (STROBE_CYC > 1)) |=> !adc_rc_n);

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_no_start_powered_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rc_n) |-> !$past(adc_pwrd));

    assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_timeout_err |-> (adc_cs_n && adc_rc_n));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    assert_rclk_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_dclk_out);
endmodule

bind adc_seq_top adc_seq_chk #(
    .DATA_W    (DATA_W),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .adc_rc_n        (adc_rc_n),
    .adc_cs_n        (adc_cs_n),
    .adc_dclk_out    (adc_dclk_out),
    .adc_pwrd        (adc_pwrd),
    .result          (result),
    .result_valid    (result_valid),
    .busy_timeout_err(busy_timeout_err)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
    localparam int STROBE = 8;
    localparam int SPACE  = 200;
    localparam int TMO    = 300;
    localparam int HALF   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, use_ext_clk = 1'b0, fmt_straight = 1'b0, pwr_down_req = 1'b0;
    logic adc_busy, adc_dclk_in, adc_data, adc_sync;
    logic adc_rc_n, adc_cs_n, adc_dclk_out, adc_pwrd;
    logic [15:0] result;
    logic result_valid, busy_timeout_err, strobe_violation;

    always #4 clk = ~clk;

    adc_seq_top #(
        .DATA_W(16), .STROBE_CYC(STROBE), .SPACING_CYC(SPACE),
        .BUSY_TMO_CYC(TMO), .RCLK_HALF(HALF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .use_ext_clk(use_ext_clk),
        .fmt_straight(fmt_straight), .pwr_down_req(pwr_down_req), .adc_busy(adc_busy),
        .adc_dclk_in(adc_dclk_in), .adc_data(adc_data), .adc_sync(adc_sync),
        .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n), .adc_dclk_out(adc_dclk_out),
        .adc_pwrd(adc_pwrd), .result(result), .result_valid(result_valid),
        .busy_timeout_err(busy_timeout_err), .strobe_violation(strobe_violation)
    );

    // converter model
    logic [15:0] vin = 16'h0;
    logic        m_dead = 1'b0;
    int          m_conv = 150;
    logic        m_busy, m_idclk, m_idata, m_esync, m_edata, m_emit;
    logic        m_rc_prev, m_dclk_prev;
    logic [15:0] m_cur, m_prev, m_eword;
    logic [3:0]  m_ebit;
    logic [2:0]  m_eph;
    logic [4:0]  m_ecnt;
    int          m_left;

    assign adc_busy    = m_busy;
    assign adc_dclk_in = m_idclk;
    assign adc_sync    = m_esync;
    assign adc_data    = use_ext_clk ? m_edata : m_idata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 1'b1; m_idclk <= 1'b0; m_idata <= 1'b0; m_esync <= 1'b0;
            m_edata <= 1'b0; m_emit <= 1'b0; m_rc_prev <= 1'b1; m_dclk_prev <= 1'b0;
            m_cur <= 16'h0; m_prev <= 16'h0; m_eword <= 16'h0; m_ebit <= 4'd0;
            m_eph <= 3'd0; m_ecnt <= 5'd0; m_left <= 0;
        end else begin
            m_rc_prev   <= adc_rc_n;
            m_dclk_prev <= adc_dclk_out;
            if (m_rc_prev && !adc_rc_n && !adc_cs_n && !m_dead) begin
                m_busy <= 1'b0; m_left <= m_conv; m_cur <= vin;
                m_eword <= m_prev; m_emit <= 1'b1; m_ebit <= 4'd15; m_eph <= 3'd0;
                m_ecnt <= 5'd0;
            end else begin
                if (m_left != 0) begin
                    if (m_left == 1) begin m_busy <= 1'b1; m_prev <= m_cur; end
                    m_left <= m_left - 1;
                end
                if (m_emit) begin
                    if (m_eph == 3'd0) begin m_idata <= m_eword[m_ebit]; m_idclk <= 1'b0; end
                    if (m_eph == 3'd4) m_idclk <= 1'b1;
                    if (m_eph == 3'd7) begin
                        if (m_ebit == 4'd0) m_emit <= 1'b0;
                        else m_ebit <= m_ebit - 4'd1;
                    end
                    m_eph <= m_eph + 3'd1;
                end else begin
                    m_idclk <= 1'b0;
                end
                if (adc_dclk_out && !m_dclk_prev) begin
                    if (m_ecnt == 5'd0) m_esync <= 1'b1;
                    else begin
                        m_esync <= 1'b0;
                        if (m_ecnt <= 5'd16) m_edata <= m_cur[16 - m_ecnt];
                    end
                    m_ecnt <= m_ecnt + 5'd1;
                end
            end
        end
    end

    // monitors
    int cyc = 0, nstrobe = 0, last_fall = -100000, min_space = 100000, low_run = 0, last_low = 0;
    logic mon_prev_rc = 1'b1, viol_seen = 1'b0, tmo_seen = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            mon_prev_rc <= adc_rc_n;
            if (!adc_rc_n) low_run <= (mon_prev_rc ? 1 : low_run + 1);
            if (adc_rc_n && !mon_prev_rc) last_low <= low_run;
            if (!adc_rc_n && mon_prev_rc) begin
                nstrobe <= nstrobe + 1;
                if (cyc - last_fall < min_space) min_space <= cyc - last_fall;
                last_fall <= cyc;
            end
            if (strobe_violation) viol_seen <= 1'b1;
            if (busy_timeout_err) tmo_seen <= 1'b1;
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
    endtask

    task automatic run_conv(input logic [15:0] v, output logic got, output logic [15:0] r);
        logic went_low;
        vin = v;
        got = 1'b0; r = 16'h0; went_low = 1'b0;
        pulse_start();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (result_valid) begin got = 1'b1; r = result; end
            if (!adc_cs_n) went_low = 1'b1;
            if (went_low && adc_cs_n) break;
        end
    endtask

    function automatic logic [15:0] pick(input int i);
        case (i)
            0: pick = 16'h0000;
            1: pick = 16'h7FFF;
            2: pick = 16'h8000;
            3: pick = 16'hFFFF;
            default: pick = 16'(i * 16'h2F1B + 16'h0135);
        endcase
    endfunction

    initial begin
        logic got;
        logic [15:0] r, last_v, expw, r0;
        int n0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_rc_n && adc_cs_n, "R1 strobe/select idle", {30'd0, adc_rc_n, adc_cs_n}, 32'h3);
        chk(!result_valid && !busy_timeout_err && !strobe_violation && !adc_dclk_out && !adc_pwrd,
            "R1 pulses low", {27'd0, result_valid, busy_timeout_err, strobe_violation, adc_dclk_out, adc_pwrd}, 0);
        chk(result == 16'h0, "R1 result zero", result, 0);

        last_v = 16'h0;
        for (int mode = 0; mode < 2; mode++) begin
            for (int f = 0; f < 2; f++) begin
                use_ext_clk = 1'(mode); fmt_straight = 1'(f);
                for (int i = 0; i < 16; i++) begin
                    run_conv(pick(i), got, r);
                    expw = (mode == 1) ? pick(i) : last_v;
                    expw = expw ^ {1'(f), 15'd0};
                    last_v = pick(i);
                    chk(got, (mode == 1) ? "R5 valid seen" : "R4 valid seen", {31'd0, got}, 1);
                    chk(r == expw, (mode == 1) ? "R5 R6 host-clock word" : "R4 R6 converter-clock word", r, expw);
                    chk(last_low == STROBE, "R2 strobe width", last_low, STROBE);
                    chk(!adc_dclk_out, "R12 read clock idle", adc_dclk_out, 0);
                end
            end
        end
        chk(!viol_seen, "R10 no violation in normal use", viol_seen, 0);

        // R7 pending start
        use_ext_clk = 1'b0; fmt_straight = 1'b0;
        n0 = nstrobe;
        vin = 16'h1234;
        pulse_start();
        repeat (30) @(negedge clk);
        vin = 16'h4321;
        pulse_start();
        repeat (1000) @(negedge clk);
        chk(nstrobe == n0 + 2, "R7 held start served once", nstrobe - n0, 2);
        chk(result == 16'h1234, "R7 second result", result, 16'h1234);
        last_v = 16'h4321;
        chk(min_space >= SPACE, "R3 start spacing", min_space, SPACE);

        // R8 power down
        pwr_down_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(adc_pwrd, "R8 power-down pin", adc_pwrd, 1);
        n0 = nstrobe; r0 = result;
        vin = 16'h0BAD;
        pulse_start();
        repeat (500) @(negedge clk);
        chk(nstrobe == n0, "R8 no strobe while down", nstrobe - n0, 0);
        chk(result == r0, "R8 result held", result, r0);
        pwr_down_req = 1'b0;
        repeat (600) @(negedge clk);
        chk(nstrobe == n0 + 1, "R8 held start after release", nstrobe - n0, 1);
        chk(result == last_v, "R8 result after release", result, last_v);
        last_v = 16'h0BAD;

        // R9 timeout
        m_dead = 1'b1; tmo_seen = 1'b0; r0 = result;
        pulse_start();
        repeat (600) @(negedge clk);
        chk(tmo_seen, "R9 timeout pulse", tmo_seen, 1);
        chk(adc_cs_n && adc_rc_n, "R9 back to idle", {30'd0, adc_rc_n, adc_cs_n}, 3);
        chk(result == r0, "R11 result unchanged on timeout", result, r0);
        m_dead = 1'b0;

        // R10 violation
        m_conv = 2; viol_seen = 1'b0; tmo_seen = 1'b0;
        run_conv(16'h5A5A, got, r);
        chk(viol_seen, "R10 violation pulse", viol_seen, 1);
        chk(!got, "R10 no word from cut conversion", got, 0);
        chk(!tmo_seen, "R10 no timeout", tmo_seen, 0);
        last_v = 16'h5A5A;
        repeat (200) @(negedge clk);
        m_conv = 150;
        run_conv(16'h0F0F, got, r);
        chk(got && r == last_v, "R4 after violation", r, last_v);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule